// File: doc/BRIEF.md
# Accumulator Logic, Rotate and Decimal-Adjust Unit

This block computes the next value of an 8-bit accumulator and its carry flag for the non-arithmetic group of a small processor datapath. Each operation completes in a single strobe. A 4-bit opcode picks one of these operations:

- bitwise AND, OR or XOR with an operand byte
- complement or clear of the accumulator
- 8-bit rotates, and 9-bit rotates through carry
- exchange of the two nibbles
- the decimal-adjust step that follows a binary add of two packed-BCD bytes

The surrounding datapath presents the current accumulator, carry and auxiliary-carry values together with the opcode and operand, and raises the strobe for one clock. The result is registered. It appears on the outputs at the clock edge that samples the strobe, and it stays there until the next strobe. Decimal adjust yields a valid two-digit BCD value only when its input is the binary sum of two BCD bytes, with the flags that add produced. It is not a general binary-to-BCD converter.

Top module: `accl_unit`

## Requirements
- R1: While reset is asserted, and after reset is released until the first strobe, acc_out is 00h and cy_out is 0.
- R2: At a clock edge where strobe is 0, acc_out and cy_out keep their values, whatever the other inputs are.
- R3: Opcodes 0h, 1h and 2h load acc_in AND, OR and XOR operand, one bit at a time. cy_out takes cy_in. An operand of FFh under XOR inverts every bit.
- R4: Opcode 3h loads the bitwise complement of acc_in and opcode 4h loads 00h. Both pass cy_in to cy_out unchanged.
- R5: Opcode 5h rotates acc_in left, so bit 7 goes to bit 0. Opcode 6h rotates it right, so bit 0 goes to bit 7. Both pass cy_in unchanged.
- R6: Opcode 7h is a 9-bit left rotate. Bit 7 of acc_in goes to cy_out and cy_in goes to bit 0.
- R7: Opcode 8h is a 9-bit right rotate. cy_in goes to bit 7 and bit 0 of acc_in goes to cy_out. With cy_in=1 and acc_in=00h the result is 80h with carry 0.
- R8: Opcode 9h exchanges bits 7:4 and bits 3:0 of acc_in. Carry is unchanged.
- R9: Opcode Ah adds 06h when bits 3:0 exceed 9 or ac_in is 1. Otherwise it leaves the low digit as it is.
- R10: After that step, opcode Ah adds 60h when bits 7:4 exceed 9 or the carry is set. cy_out is 1 when cy_in was 1 or either addition passes FFh. This opcode never clears the carry.
- R11: Opcodes Bh to Fh load acc_in and cy_in unchanged.
- R12: A strobe sampled at one clock edge places its result on the outputs at that same edge. It takes one strobe and no added cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strobe | input | 1 | Execute the selected operation at this edge |
| opcode | input | 4 | Operation select (encoding in R3 to R11) |
| operand | input | 8 | Second operand for the bitwise operations |
| acc_in | input | 8 | Current accumulator value |
| cy_in | input | 1 | Current carry flag |
| ac_in | input | 1 | Current auxiliary-carry flag |
| acc_out | output | 8 | Registered new accumulator |
| cy_out | output | 1 | Registered new carry flag |

## Verification
The hardest case to reach is the decimal adjust where the low-digit correction itself produces the condition for the high-digit correction. A second hard case is a carry that arrives set while neither digit needs a fix, because that is where a design might clear the flag. The stimulus uses hand-chosen sums such as 9Ah, which overflows to 00h with carry, and 12h with carry already set, which must become 72h with carry kept. It also uses a value that needs only the auxiliary-carry fix, to separate the two triggers. The 9-bit rotates are driven with both carry values so that a crossed wire between bit 0 and bit 7 shows up.

// File: rtl/accl_pkg.sv
package accl_pkg;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [3:0] {
    OP_AND  = 4'h0,
    OP_OR   = 4'h1,
    OP_XOR  = 4'h2,
    OP_CPL  = 4'h3,
    OP_CLR  = 4'h4,
    OP_ROL  = 4'h5,
    OP_ROR  = 4'h6,
    OP_ROLC = 4'h7,
    OP_RORC = 4'h8,
    OP_SWAP = 4'h9,
    OP_DADJ = 4'hA
  } accl_op_e;
endpackage

// File: rtl/accl_rst_sync.sv
module accl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/accl_logic.sv
module accl_logic
  import accl_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  accl_op_e       op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y
);
  always_comb begin
    unique case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_CPL:  y = ~a;
      OP_CLR:  y = '0;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/accl_rotate.sv
module accl_rotate
  import accl_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  accl_op_e       op,
  input  logic [W-1:0]   a,
  input  logic           cy,
  output logic [W-1:0]   y,
  output logic           cy_o
);
  localparam int unsigned NIB_W = W / 2;

  always_comb begin
    y    = a;
    cy_o = cy;
    unique case (op)
      OP_ROL:  y = {a[W-2:0], a[W-1]};
      OP_ROR:  y = {a[0], a[W-1:1]};
      OP_ROLC: begin
        y    = {a[W-2:0], cy};
        cy_o = a[W-1];
      end
      OP_RORC: begin
        y    = {cy, a[W-1:1]};
        cy_o = a[0];
      end
      OP_SWAP: y = {a[NIB_W-1:0], a[W-1:NIB_W]};
      default: begin
        y    = a;
        cy_o = cy;
      end
    endcase
  end
endmodule

// File: rtl/accl_dadj.sv
module accl_dadj
  import accl_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0]   a,
  input  logic           cy,
  input  logic           ac,
  output logic [W-1:0]   y,
  output logic           cy_o
);
  localparam int unsigned NIB_W  = W / 2;
  localparam logic [W:0]  LO_ADD = (W+1)'(6);
  localparam logic [W:0]  HI_ADD = (W+1)'(6) << NIB_W;
  localparam logic [NIB_W-1:0] DIGIT_MAX = NIB_W'(9);

  logic         lo_fix, hi_fix, c1;
  logic [W:0]   s1, s2;

  always_comb begin
    lo_fix = (a[NIB_W-1:0] > DIGIT_MAX) | ac;
    s1     = {1'b0, a} + (lo_fix ? LO_ADD : '0);
    c1     = cy | s1[W];
    hi_fix = (s1[W-1:NIB_W] > DIGIT_MAX) | c1;
    s2     = {1'b0, s1[W-1:0]} + (hi_fix ? HI_ADD : '0);
    y      = s2[W-1:0];
    cy_o   = c1 | s2[W];
  end
endmodule

// File: rtl/accl_unit.sv
module accl_unit
  import accl_pkg::*;
#(
  parameter int unsigned W           = DATA_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic [3:0]   opcode,
  input  logic [7:0]   operand,
  input  logic [7:0]   acc_in,
  input  logic         cy_in,
  input  logic         ac_in,
  output logic [7:0]   acc_out,
  output logic         cy_out
);
  localparam int unsigned NIB_W = W / 2;

  accl_op_e     op;
  logic         rst_q_n;
  logic [W-1:0] log_y, rot_y, da_y;
  logic         rot_cy, da_cy;
  logic [W-1:0] acc_d, acc_q;
  logic         cy_d, cy_q;

  assign op = accl_op_e'(opcode);

  accl_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_q_n)
  );

  accl_logic #(.W(W)) u_logic (
    .op(op), .a(acc_in), .b(operand), .y(log_y)
  );

  accl_rotate #(.W(W)) u_rot (
    .op(op), .a(acc_in), .cy(cy_in), .y(rot_y), .cy_o(rot_cy)
  );

  accl_dadj #(.W(W)) u_da (
    .a(acc_in), .cy(cy_in), .ac(ac_in), .y(da_y), .cy_o(da_cy)
  );

  // next-state selection
  always_comb begin
    acc_d = acc_q;
    cy_d  = cy_q;
    if (strobe) begin
      unique case (op)
        OP_AND, OP_OR, OP_XOR, OP_CPL, OP_CLR: begin
          acc_d = log_y;
          cy_d  = cy_in;
        end
        OP_ROL, OP_ROR, OP_ROLC, OP_RORC, OP_SWAP: begin
          acc_d = rot_y;
          cy_d  = rot_cy;
        end
        OP_DADJ: begin
          acc_d = da_y;
          cy_d  = da_cy;
        end
        default: begin
          acc_d = acc_in;
          cy_d  = cy_in;
        end
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      acc_q <= '0;
      cy_q  <= 1'b0;
    end else begin
      acc_q <= acc_d;
      cy_q  <= cy_d;
    end
  end

  assign acc_out = acc_q;
  assign cy_out  = cy_q;

  // R2: idle edges hold state
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    !strobe |=> ($stable(acc_out) && $stable(cy_out)));

  // R3, R4: bitwise group keeps carry
  a_r3_logic_keeps_carry: assert property (@(posedge clk) disable iff (!rst_q_n)
    (strobe && (opcode <= 4'h4)) |=> (cy_out == $past(cy_in)));

  // R5: plain left rotate wraps bit 7 to bit 0
  a_r5_rol_wrap: assert property (@(posedge clk) disable iff (!rst_q_n)
    (strobe && opcode == 4'h5) |=> (acc_out[0] == $past(acc_in[7]) && cy_out == $past(cy_in)));

  // R6: 9-bit left rotate
  a_r6_rolc_ring: assert property (@(posedge clk) disable iff (!rst_q_n)
    (strobe && opcode == 4'h7) |=> (cy_out == $past(acc_in[7]) && acc_out[0] == $past(cy_in)));

  // R7: 9-bit right rotate
  a_r7_rorc_ring: assert property (@(posedge clk) disable iff (!rst_q_n)
    (strobe && opcode == 4'h8) |=> (cy_out == $past(acc_in[0]) && acc_out[7] == $past(cy_in)));

  // R8: nibble exchange
  a_r8_swap_halves: assert property (@(posedge clk) disable iff (!rst_q_n)
    (strobe && opcode == 4'h9) |=>
      (acc_out == {$past(acc_in[NIB_W-1:0]), $past(acc_in[W-1:NIB_W])}));

  // R10: decimal adjust never clears carry
  a_r10_da_carry_sticky: assert property (@(posedge clk) disable iff (!rst_q_n)
    (strobe && opcode == 4'hA && cy_in) |=> cy_out);

  // R11: reserved codes pass inputs through
  a_r11_reserved_pass: assert property (@(posedge clk) disable iff (!rst_q_n)
    (strobe && opcode >= 4'hB) |=> (acc_out == $past(acc_in) && cy_out == $past(cy_in)));
endmodule

// File: tb/accl_unit_tb.sv
`timescale 1ns/1ps
module accl_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       strobe;
  logic [3:0] opcode;
  logic [7:0] operand, acc_in;
  logic       cy_in, ac_in;
  logic [7:0] acc_out;
  logic       cy_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  accl_unit u_dut (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .opcode(opcode),
    .operand(operand), .acc_in(acc_in), .cy_in(cy_in), .ac_in(ac_in),
    .acc_out(acc_out), .cy_out(cy_out)
  );

  task automatic check(string req, logic [7:0] ea, logic ec);
    n_chk++;
    if (acc_out !== ea || cy_out !== ec) begin
      n_bad++;
      $display("FAIL %s: acc=%02h cy=%0b expected acc=%02h cy=%0b",
               req, acc_out, cy_out, ea, ec);
    end
  endtask

  // one strobe, then sample at the following falling edge
  task automatic run_op(string req, logic [3:0] opc, logic [7:0] opd,
                        logic [7:0] a, logic c, logic h,
                        logic [7:0] ea, logic ec);
    @(negedge clk);
    opcode = opc; operand = opd; acc_in = a; cy_in = c; ac_in = h;
    strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    check(req, ea, ec);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; strobe = 1'b0; opcode = 4'h0; operand = 8'h00;
    acc_in = 8'hFF; cy_in = 1'b1; ac_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 in reset", 8'h00, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", 8'h00, 1'b0);
  endtask

  task automatic t_logic;
    run_op("R3 and", 4'h0, 8'h11, 8'h35, 1'b1, 1'b0, 8'h11, 1'b1);
    run_op("R3 or",  4'h1, 8'hC0, 8'h35, 1'b0, 1'b0, 8'hF5, 1'b0);
    run_op("R3 xor invert", 4'h2, 8'hFF, 8'h35, 1'b1, 1'b0, 8'hCA, 1'b1);
    run_op("R4 cpl", 4'h3, 8'h00, 8'h5A, 1'b1, 1'b1, 8'hA5, 1'b1);
    run_op("R4 clr", 4'h4, 8'hFF, 8'h77, 1'b0, 1'b1, 8'h00, 1'b0);
  endtask

  task automatic t_hold;
    run_op("R12 single strobe", 4'h1, 8'h0F, 8'hA0, 1'b1, 1'b0, 8'hAF, 1'b1);
    @(negedge clk);
    opcode = 4'h4; acc_in = 8'h33; cy_in = 1'b0; operand = 8'h55;
    repeat (3) @(negedge clk);
    check("R2 hold", 8'hAF, 1'b1);
  endtask

  task automatic t_rotate;
    run_op("R5 rol c0", 4'h5, 8'h00, 8'h81, 1'b0, 1'b0, 8'h03, 1'b0);
    run_op("R5 rol c1", 4'h5, 8'h00, 8'h81, 1'b1, 1'b0, 8'h03, 1'b1);
    run_op("R5 ror",    4'h6, 8'h00, 8'h01, 1'b0, 1'b0, 8'h80, 1'b0);
    run_op("R6 rolc a", 4'h7, 8'h00, 8'h80, 1'b0, 1'b0, 8'h00, 1'b1);
    run_op("R6 rolc b", 4'h7, 8'h00, 8'h01, 1'b1, 1'b0, 8'h03, 1'b0);
    run_op("R7 rorc a", 4'h8, 8'h00, 8'h00, 1'b1, 1'b0, 8'h80, 1'b0);
    run_op("R7 rorc b", 4'h8, 8'h00, 8'h01, 1'b0, 1'b0, 8'h00, 1'b1);
  endtask

  task automatic t_swap;
    run_op("R8 swap a", 4'h9, 8'h00, 8'h3C, 1'b1, 1'b0, 8'hC3, 1'b1);
    run_op("R8 swap b", 4'h9, 8'h00, 8'h59, 1'b0, 1'b0, 8'h95, 1'b0);
  endtask

  task automatic t_dadj;
    run_op("R9 low digit",  4'hA, 8'h00, 8'h0F, 1'b0, 1'b0, 8'h15, 1'b0);
    run_op("R9 aux carry",  4'hA, 8'h00, 8'h12, 1'b0, 1'b1, 8'h18, 1'b0);
    run_op("R9 no fix",     4'hA, 8'h00, 8'h45, 1'b0, 1'b0, 8'h45, 1'b0);
    run_op("R10 both wrap", 4'hA, 8'h00, 8'h9A, 1'b0, 1'b0, 8'h00, 1'b1);
    run_op("R10 carry kept",4'hA, 8'h00, 8'h12, 1'b1, 1'b0, 8'h72, 1'b1);
    run_op("R10 high digit",4'hA, 8'h00, 8'hB3, 1'b0, 1'b0, 8'h13, 1'b1);
  endtask

  task automatic t_reserved;
    run_op("R11 code B", 4'hB, 8'hFF, 8'h3E, 1'b1, 1'b1, 8'h3E, 1'b1);
    run_op("R11 code F", 4'hF, 8'h00, 8'hC1, 1'b0, 1'b0, 8'hC1, 1'b0);
  endtask

  initial begin
    t_reset();
    t_logic();
    t_hold();
    t_rotate();
    t_swap();
    t_dadj();
    t_reserved();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: acc=%02h cy=%0b expected completion", acc_out, cy_out);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule